// File: doc/BRIEF.md
# Combined Channel Interrupt Logic for a Mailbox Receiver

This block sits beside the channel window storage of a mailbox receiver. For every channel it takes the pending word (status with the mask already removed) and marks the channel as holding data when that word is nonzero. The resulting flags form a 128-bit bitmap. Software reads it as four 32-bit combined status registers, where bit n of register r belongs to channel 32*r + n. A priority search across the bitmap, from the lowest bit of register 0 upward, gives the lowest active channel. Software reads that index from a helper register and services that channel first.

The block also holds the interrupt enable, status and clear registers for the two ready-state change events. It carries the implementer and architecture identification registers. It drives a level interrupt. A two-state machine holds the interrupt line: IRQ_IDLE moves to IRQ_RAISED (transition RAISE) in the cycle after a cause appears, and IRQ_RAISED returns to IRQ_IDLE (transition DROP) in the cycle after every cause is gone. The line follows the data level, so software needs no acknowledge. When it clears one channel out of several, the interrupt stays up for another pass.

Top module: `mbx_cmb_irq`

## Requirements
- R1: The combined status register at address 0xFA0 + 4*r (r = 0..3) has bit n set exactly when the pending word of channel 32*r + n is nonzero. Bits for channels at or above NUM_CH read 0. The value follows the inputs in the same cycle.
- R2: The register at 0xFB0 returns the lowest channel index with a nonzero pending word in bits [6:0] and a valid flag in bit 31. All other bits read 0. When no channel is pending, the whole word reads 0.
- R3: The enable register at 0xF98 is read/write in bits [2:0]. Bit 0 enables the ready-to-not-ready event, bit 1 enables the not-ready-to-ready event, and bit 2 enables the combined channel interrupt. Bits [31:3] read 0.
- R4: The status register at 0xF90 is read-only. A one-cycle pulse on ev_to_ready sets bit 0, and a pulse on ev_to_notready sets bit 1. Both bits stay set until they are cleared. Bits [31:2] read 0.
- R5: Writing the clear register at 0xF94 clears each status bit whose matching write-data bit is 1. A 0 in a write-data bit leaves that status bit unchanged. An event in the same cycle as the clear wins, so its bit stays set. The clear register reads 0.
- R6: irq is registered. In the cycle after an edge it equals (enable bit 2 AND any channel pending) OR (enable bit 1 AND status bit 0) OR (enable bit 0 AND status bit 1), all sampled at that edge.
- R7: irq stays asserted while any channel is still pending with the combined enable set. Clearing one of two pending channels leaves it high, and it falls one cycle after the last channel clears.
- R8: The register at 0xFCC returns the minor revision 1 in bits [3:0] and ARCH_MAJOR in bits [7:4]. The register at 0xFC8 packs IMPL_CODE [11:0], REV_CODE [15:12], VAR_CODE [19:16] and PROD_CODE [31:20].
- R9: After reset, irq, the enable register and the status register are all 0.
- R10: Addresses that are not mapped read 0. Writes to the read-only registers and to unmapped addresses change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_words | input | NUM_CH*WORD_W | Pending word per channel, channel c at bits [c*WORD_W +: WORD_W] |
| ev_to_ready | input | 1 | One-cycle pulse: the link changed from not-ready to ready |
| ev_to_notready | input | 1 | One-cycle pulse: the link changed from ready to not-ready |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default NUM_CH of 124. That puts the last real channel at bit 27 of the fourth combined register and leaves bits 28 to 31 as unused positions that must read 0. Pending channels are placed in registers 0, 1 and 3 and left empty in register 2, which exercises the search across an empty register and into the highest channel. Channels are then retired one at a time so the helper index moves upward and the interrupt stays up between passes. The event status bits are checked under clear-only writes, zero writes, and a clear that collides with an event in the same cycle.

// File: rtl/mbx_cirq_pkg.sv
package mbx_cirq_pkg;
    localparam int unsigned REG_W    = 32;
    localparam int unsigned CMB_REGS = 4;
    localparam int unsigned MAP_BITS = CMB_REGS * REG_W;
    localparam int unsigned IDX_W    = $clog2(MAP_BITS);

    localparam logic [11:0] A_INT_ST  = 12'hF90;
    localparam logic [11:0] A_INT_CLR = 12'hF94;
    localparam logic [11:0] A_INT_EN  = 12'hF98;
    localparam logic [7:0]  A_CMB_HI  = 8'hFA;
    localparam logic [11:0] A_LOWEST  = 12'hFB0;
    localparam logic [11:0] A_IMPL_ID = 12'hFC8;
    localparam logic [11:0] A_ARCH_ID = 12'hFCC;

    localparam logic [3:0]  ARCH_MINOR = 4'd1;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/cirq_chan_map.sv
module cirq_chan_map
    import mbx_cirq_pkg::*;
#(
    parameter int unsigned NUM_CH = 124,
    parameter int unsigned WORD_W = 32
) (
    input  logic [NUM_CH*WORD_W-1:0] pend_words,
    output logic [MAP_BITS-1:0]      bitmap
);
    for (genvar g = 0; g < MAP_BITS; g++) begin : g_bit
        if (g < NUM_CH) begin : g_live
            assign bitmap[g] = |pend_words[g*WORD_W +: WORD_W];
        end else begin : g_absent
            assign bitmap[g] = 1'b0;
        end
    end
endmodule

// File: rtl/cirq_lowest.sv
module cirq_lowest
    import mbx_cirq_pkg::*;
(
    input  logic [MAP_BITS-1:0] bitmap,
    output logic [IDX_W-1:0]    low_idx,
    output logic                low_found
);
    always_comb begin
        low_idx   = '0;
        low_found = 1'b0;
        for (int i = MAP_BITS - 1; i >= 0; i--) begin
            if (bitmap[i]) begin
                low_idx   = IDX_W'(i);
                low_found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cirq_irq_fsm.sv
module cirq_irq_fsm
    import mbx_cirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cause,
    output logic irq
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (cause)  state_d = IRQ_RAISED; // RAISE
            IRQ_RAISED: if (!cause) state_d = IRQ_IDLE;   // DROP
        endcase
    end

    always_comb begin
        unique case (state_q)
            IRQ_IDLE:   irq = 1'b0;
            IRQ_RAISED: irq = 1'b1;
        endcase
    end
endmodule

// File: rtl/mbx_cmb_irq.sv
module mbx_cmb_irq
    import mbx_cirq_pkg::*;
#(
    parameter int unsigned NUM_CH     = 124,
    parameter int unsigned WORD_W     = 32,
    parameter logic [3:0]  ARCH_MAJOR = 4'd2,
    parameter logic [11:0] IMPL_CODE  = 12'h3A5,
    parameter logic [3:0]  REV_CODE   = 4'h1,
    parameter logic [3:0]  VAR_CODE   = 4'h0,
    parameter logic [11:0] PROD_CODE  = 12'h0C2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH*WORD_W-1:0] pend_words,
    input  logic                     ev_to_ready,
    input  logic                     ev_to_notready,
    input  logic                     reg_wr,
    input  logic [11:0]              reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    output logic                     irq
);
    localparam int unsigned EN_W = 3;
    localparam int unsigned ST_W = 2;

    logic [MAP_BITS-1:0] bitmap;
    logic [IDX_W-1:0]    low_idx;
    logic                low_found;
    logic [EN_W-1:0]     en_q;      // [0] to-not-ready, [1] to-ready, [2] combined
    logic [ST_W-1:0]     st_q;      // [0] to-ready, [1] to-not-ready
    logic [ST_W-1:0]     st_d;
    logic                cause;
    logic                unused_wdata;

    assign unused_wdata = ^reg_wdata[31:EN_W];

    cirq_chan_map #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_map (
        .pend_words (pend_words),
        .bitmap     (bitmap)
    );

    cirq_lowest u_low (
        .bitmap    (bitmap),
        .low_idx   (low_idx),
        .low_found (low_found)
    );

    always_comb begin
        st_d = st_q;
        if (reg_wr && reg_addr == A_INT_CLR) st_d = st_d & ~reg_wdata[ST_W-1:0];
        if (ev_to_ready)    st_d[0] = 1'b1;
        if (ev_to_notready) st_d[1] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
            st_q <= '0;
        end else begin
            st_q <= st_d;
            if (reg_wr && reg_addr == A_INT_EN) en_q <= reg_wdata[EN_W-1:0];
        end
    end

    assign cause = (en_q[2] && low_found) || (en_q[1] && st_q[0]) || (en_q[0] && st_q[1]);

    cirq_irq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .cause (cause),
        .irq   (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[11:4] == A_CMB_HI && reg_addr[1:0] == 2'b00) begin
            reg_rdata = bitmap[reg_addr[3:2]*REG_W +: REG_W];
        end else begin
            case (reg_addr)
                A_INT_ST:  reg_rdata = {{(32-ST_W){1'b0}}, st_q};
                A_INT_EN:  reg_rdata = {{(32-EN_W){1'b0}}, en_q};
                A_LOWEST:  reg_rdata = {low_found, {(31-IDX_W){1'b0}}, low_idx};
                A_IMPL_ID: reg_rdata = {PROD_CODE, VAR_CODE, REV_CODE, IMPL_CODE};
                A_ARCH_ID: reg_rdata = {24'd0, ARCH_MAJOR, ARCH_MINOR};
                default:   reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/mbx_cmb_irq_chk.sv
module mbx_cmb_irq_chk #(
    parameter int unsigned NUM_CH = 124,
    parameter int unsigned WORD_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CH*WORD_W-1:0] pend_words,
    input logic                     ev_to_ready,
    input logic                     ev_to_notready,
    input logic                     reg_wr,
    input logic [11:0]              reg_addr,
    input logic [31:0]              reg_wdata,
    input logic [2:0]               en_q,
    input logic [1:0]               st_q,
    input logic                     irq
);
    logic any_pend;
    logic clr_wr;
    assign any_pend = |pend_words;
    assign clr_wr   = reg_wr && reg_addr == 12'hF94;

    a_r6_cmb_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[2] && any_pend) |=> irq);

    a_r7_quiet_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (!(en_q[2] && any_pend) && !(en_q[1] && st_q[0]) && !(en_q[0] && st_q[1])) |=> !irq);

    a_r4_ready_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        ev_to_ready |=> st_q[0]);

    a_r4_notready_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        ev_to_notready |=> st_q[1]);

    a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && reg_wdata[0] && !ev_to_ready) |=> !st_q[0]);

    a_r5_held_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q[1] && !(clr_wr && reg_wdata[1])) |=> st_q[1]);

    a_r9_reset_clean: assert property (@(posedge clk)
        $rose(rst_n) |-> (!irq && en_q == 3'd0 && st_q == 2'd0));
endmodule

bind mbx_cmb_irq mbx_cmb_irq_chk #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pend_words     (pend_words),
    .ev_to_ready    (ev_to_ready),
    .ev_to_notready (ev_to_notready),
    .reg_wr         (reg_wr),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .en_q           (en_q),
    .st_q           (st_q),
    .irq            (irq)
);

// File: tb/tb_mbx_cmb_irq.sv
module tb_mbx_cmb_irq;
    localparam int NCH = 124;
    localparam int WW  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH*WW-1:0] pend_words = '0;
    logic              ev_to_ready = 1'b0;
    logic              ev_to_notready = 1'b0;
    logic              reg_wr = 1'b0;
    logic [11:0]       reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [2:0]  m_en = '0;
    logic [1:0]  m_st = '0;
    logic        m_irq = 1'b0;
    int unsigned m_pend [NCH];

    mbx_cmb_irq dut (
        .clk(clk), .rst_n(rst_n), .pend_words(pend_words),
        .ev_to_ready(ev_to_ready), .ev_to_notready(ev_to_notready),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit any_pend();
        for (int c = 0; c < NCH; c++) if (m_pend[c] != 0) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] model_read(logic [11:0] a);
        logic [31:0] v = '0;
        if (a >= 12'hFA0 && a <= 12'hFAC && a[1:0] == 2'b00) begin
            for (int n = 0; n < 32; n++) begin
                int c = (int'(a - 12'hFA0) / 4) * 32 + n;
                if (c < NCH && m_pend[c] != 0) v[n] = 1'b1;
            end
            return v;
        end
        case (a)
            12'hF90: return {30'd0, m_st};
            12'hF98: return {29'd0, m_en};
            12'hFB0: begin
                for (int c = 0; c < NCH; c++)
                    if (m_pend[c] != 0) return 32'h8000_0000 | c;
                return 32'd0;
            end
            12'hFC8: return {12'h0C2, 4'h0, 4'h1, 12'h3A5};
            12'hFCC: return 32'h0000_0021;
            default: return 32'd0;
        endcase
    endfunction

    // one clock: model updates at the edge, irq compared half a period later
    task automatic tick();
        logic cause;
        @(posedge clk);
        if (rst_n) begin
            cause = (m_en[2] && any_pend()) || (m_en[1] && m_st[0]) || (m_en[0] && m_st[1]);
            if (reg_wr && reg_addr == 12'hF98) m_en = reg_wdata[2:0];
            if (reg_wr && reg_addr == 12'hF94) m_st = m_st & ~reg_wdata[1:0];
            if (ev_to_ready)    m_st[0] = 1'b1;
            if (ev_to_notready) m_st[1] = 1'b1;
            m_irq = cause;
        end
        @(negedge clk);
        chk("R6 irq vs model", {31'd0, irq}, {31'd0, m_irq});
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [11:0] a, string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, model_read(a));
    endtask

    task automatic rd_exp(logic [11:0] a, logic [31:0] exp, string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
        chk({tag, " model"}, reg_rdata, model_read(a));
    endtask

    task automatic set_ch(int c, int unsigned v);
        m_pend[c] = v;
        pend_words[c*WW +: WW] = v;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R6 actual=hung expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) m_pend[c] = 0;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        // R9 reset state
        chk("R9 irq after reset", {31'd0, irq}, 32'd0);
        rd_exp(12'hF98, 32'd0, "R9 enable after reset");
        rd_exp(12'hF90, 32'd0, "R9 status after reset");
        // R8 identification
        rd_exp(12'hFCC, 32'h21, "R8 arch id");
        rd_exp(12'hFC8, 32'h0C2013A5, "R8 impl id");
        // R10 unmapped and read-only
        rd_exp(12'hF84, 32'd0, "R10 unmapped read");
        wr(12'hFA0, 32'hFFFF_FFFF);
        wr(12'hF90, 32'h3);
        wr(12'hFB0, 32'hFFFF_FFFF);
        rd_exp(12'hFA0, 32'd0, "R10 cmb0 after write");
        rd_exp(12'hF90, 32'd0, "R10 status after write");
        rd_exp(12'hFB0, 32'd0, "R2 no channel pending");
        // R1 bitmap layout with empty register 2
        set_ch(5, 32'h10);
        set_ch(40, 32'h1);
        set_ch(123, 32'h8000_0000);
        rd_exp(12'hFA0, 32'h0000_0020, "R1 cmb0");
        rd_exp(12'hFA4, 32'h0000_0100, "R1 cmb1");
        rd_exp(12'hFA8, 32'h0000_0000, "R1 cmb2 empty");
        rd_exp(12'hFAC, 32'h0800_0000, "R1 cmb3 top channel");
        rd_exp(12'hFB0, 32'h8000_0005, "R2 lowest is 5");
        tick();
        chk("R6 irq off while disabled", {31'd0, irq}, 32'd0);
        // R3 enable register
        wr(12'hF98, 32'hFFFF_FFFC);
        rd_exp(12'hF98, 32'h4, "R3 enable readback");
        tick();
        chk("R6 irq raised", {31'd0, irq}, 32'd1);
        // R7 service one channel at a time
        set_ch(5, 0);
        rd_exp(12'hFB0, 32'h8000_0028, "R2 lowest is 40");
        tick();
        chk("R7 irq held after one clear", {31'd0, irq}, 32'd1);
        set_ch(40, 0);
        rd_exp(12'hFB0, 32'h8000_007B, "R2 lowest is 123");
        tick();
        chk("R7 irq held for last channel", {31'd0, irq}, 32'd1);
        set_ch(123, 0);
        rd_exp(12'hFB0, 32'd0, "R2 none after drain");
        tick();
        chk("R7 irq falls after last clear", {31'd0, irq}, 32'd0);
        // R4 / R5 event status
        ev_to_ready = 1'b1; tick(); ev_to_ready = 1'b0;
        rd_exp(12'hF90, 32'h1, "R4 ready event sets bit0");
        ev_to_notready = 1'b1; tick(); ev_to_notready = 1'b0;
        rd_exp(12'hF90, 32'h3, "R4 both bits set");
        wr(12'hF98, 32'h2);
        tick();
        chk("R6 irq from ready event", {31'd0, irq}, 32'd1);
        wr(12'hF94, 32'h0);
        rd_exp(12'hF90, 32'h3, "R5 zero write keeps status");
        rd_exp(12'hF94, 32'd0, "R5 clear reads zero");
        wr(12'hF94, 32'h1);
        rd_exp(12'hF90, 32'h2, "R5 clear bit0");
        tick();
        chk("R6 irq drops with bit0", {31'd0, irq}, 32'd0);
        wr(12'hF98, 32'h1);
        tick();
        chk("R6 irq from not-ready event", {31'd0, irq}, 32'd1);
        ev_to_ready = 1'b1;
        wr(12'hF94, 32'h3);
        ev_to_ready = 1'b0;
        rd_exp(12'hF90, 32'h1, "R5 event beats clear");
        tick();
        chk("R6 irq off after clear", {31'd0, irq}, 32'd0);
        // R6 combined disabled with data present
        set_ch(77, 32'h0000_0100);
        wr(12'hF98, 32'h0);
        tick();
        chk("R6 disabled cmb no irq", {31'd0, irq}, 32'd0);
        wr(12'hF98, 32'h4);
        tick();
        chk("R6 cmb enable raises", {31'd0, irq}, 32'd1);
        rd_exp(12'hFA8, 32'h0000_2000, "R1 cmb2 channel 77");
        repeat (4) tick();
        done = 1;
        summary();
        $finish;
    end
endmodule